// File: doc/BRIEF.md
# Interrupt Cause Register with Moderation Timer

This block collects interrupt cause events from datapath logic into a sticky cause vector, and it paces outgoing interrupt messages with a programmable countdown. A message is requested whenever the countdown has reached zero and at least one cause is pending. The message is taken when the transport accepts it. At that moment the countdown reloads with the interval, without waiting for software to clear anything. Every cause bit that is enabled in the auto-clear mask is cleared in the same step.

Software reaches the cause vector and the auto-clear mask through a simple register port. A register select picks which of the two is read or written:

- Writing the cause vector clears each bit written as one.
- Reading the cause vector clears either every bit or, when the read-clear-select input is set, only the bits named in the fixed "other causes" parameter mask.

A cause event that lands in the same cycle as any clear always wins, so no event is lost.

Top module: `intr_cause_mod`

## Requirements
- R1: A clock edge with `rst_n` low clears the cause vector and the auto-clear mask, and loads the countdown with `interval`. All resets are synchronous.
- R2: A cause bit becomes 1 on the clock edge at which its `cause_evt` bit is 1. It then stays 1 until a clear mechanism removes it.
- R3: `msg_valid` is 1 exactly when the countdown is zero and the cause vector is nonzero. `msg_causes` always shows the current cause vector.
- R4: A message is sent when `msg_valid` and `msg_ready` are both 1. On that edge the countdown loads `interval`. Otherwise the countdown decrements by one each cycle while it is nonzero, and it holds at zero.
- R5: On a send, each cause bit whose auto-clear mask bit is 1 is cleared. Bits whose mask bit is 0 are left unchanged and keep `msg_valid` asserted.
- R6: A host write with `host_sel`=0 clears every cause bit where `host_wdata` is 1 and leaves every other cause bit unchanged.
- R7: A host read with `host_sel`=0 clears all cause bits when `rd_other_only`=0. When `rd_other_only`=1 it clears only the bits set in parameter `OTHER_MASK`. `host_rdata` shows the value as it was before the clear.
- R8: When a cause event and any clear (send, write or read) hit the same bit in the same cycle, the bit ends up set.
- R9: With `interval`=0, a message is sent in every cycle in which a cause is pending and `msg_ready` is 1.
- R10: A host write with `host_sel`=1 loads the auto-clear mask, and a read with `host_sel`=1 returns it. Neither access changes the cause vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cause_evt | input | NCAUSE | One bit per cause; 1 sets the cause bit |
| interval | input | TW | Moderation interval in cycles |
| rd_other_only | input | 1 | Read clears only the `OTHER_MASK` bits when 1 |
| host_sel | input | 1 | Register select: 0 = cause vector, 1 = auto-clear mask |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | NCAUSE | Host write data |
| host_rdata | output | NCAUSE | Selected register value |
| msg_valid | output | 1 | Interrupt message request |
| msg_ready | input | 1 | Transport accepts the message |
| msg_causes | output | NCAUSE | Current cause vector sent with the message |

## Verification
The bench builds the block with eight causes, a 4-bit interval and `OTHER_MASK` = 8'hC3. The narrow counter lets random intervals span the full range, including 0 and the maximum of 15, within a short run. Because the mask mixes low and high bits, a read with `rd_other_only`=1 leaves a visible pattern of surviving bits on both sides of the vector. Random reads, writes, events and transport stalls then regularly line up on the same bit in the same cycle as a send. This exercises the rule that an event wins over a clear, and it also produces sends that find nothing left to do.

// File: rtl/intr_cause_mod.sv
module intr_cause_mod #(
  parameter int NCAUSE = 8,
  parameter int TW = 6,
  parameter logic [NCAUSE-1:0] OTHER_MASK = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] cause_evt,
  input  logic [TW-1:0]     interval,
  input  logic              rd_other_only,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [NCAUSE-1:0] host_wdata,
  output logic [NCAUSE-1:0] host_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [NCAUSE-1:0] msg_causes
);

  localparam logic [NCAUSE-1:0] ALL_ONES = '1;

  logic [NCAUSE-1:0] cause_q, mask_q;
  logic [TW-1:0]     cnt_q;
  logic              fire;
  logic [NCAUSE-1:0] clr_send, clr_wr, clr_rd, clr_all;

  assign msg_valid  = (cnt_q == '0) && (|cause_q);
  assign fire       = msg_valid && msg_ready;
  assign msg_causes = cause_q;
  assign host_rdata = host_sel ? mask_q : cause_q;

  assign clr_send = fire ? mask_q : '0;
  assign clr_wr   = (host_wr && !host_sel) ? host_wdata : '0;
  assign clr_rd   = (host_rd && !host_sel) ? (rd_other_only ? OTHER_MASK : ALL_ONES) : '0;
  assign clr_all  = clr_send | clr_wr | clr_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
      cnt_q   <= interval;
    end else begin
      cause_q <= (cause_q & ~clr_all) | cause_evt;
      if (host_wr && host_sel) mask_q <= host_wdata;
      if (fire)                cnt_q <= interval;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

module intr_cause_mod_chk #(
  parameter int NCAUSE = 8,
  parameter int TW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCAUSE-1:0] cause_evt,
  input logic [NCAUSE-1:0] cause_q,
  input logic [NCAUSE-1:0] mask_q,
  input logic [TW-1:0]     cnt_q,
  input logic [TW-1:0]     interval,
  input logic              fire
);

  AST_RELOAD_ON_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cnt_q == $past(interval)); // R4

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R4

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cnt_q == '0) |=> cnt_q == '0); // R4

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_evt != '0) |=> (cause_q & $past(cause_evt)) == $past(cause_evt)); // R8

  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cause_q & $past(mask_q) & ~$past(cause_evt)) == '0); // R5

endmodule

bind intr_cause_mod intr_cause_mod_chk #(.NCAUSE(NCAUSE), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cause_evt(cause_evt), .cause_q(cause_q),
  .mask_q(mask_q), .cnt_q(cnt_q), .interval(interval), .fire(fire)
);

// File: tb/sim_intr_cause_mod.sv
module sim_intr_cause_mod;
  localparam int N = 8;
  localparam int TW = 4;
  localparam logic [N-1:0] OTHER = 8'hC3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] cause_evt = '0, host_wdata = '0;
  logic [TW-1:0] interval = 4'd3;
  logic rd_other_only = 0, host_sel = 0, host_wr = 0, host_rd = 0, msg_ready = 0;
  logic [N-1:0] host_rdata, msg_causes;
  logic msg_valid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [N-1:0] ecause, emask;
  logic [TW-1:0] ecnt;

  always #5 clk = ~clk;

  intr_cause_mod #(.NCAUSE(N), .TW(TW), .OTHER_MASK(OTHER)) u0 (
    .clk(clk), .rst_n(rst_n), .cause_evt(cause_evt), .interval(interval),
    .rd_other_only(rd_other_only), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_causes(msg_causes));

  function automatic logic exp_valid();
    return (ecnt == '0) && (ecause != '0);
  endfunction

  function automatic logic [N-1:0] exp_next_cause();
    logic [N-1:0] clr = '0;
    if (exp_valid() && msg_ready) clr |= emask;
    if (host_wr && !host_sel) clr |= host_wdata;
    if (host_rd && !host_sel) clr |= rd_other_only ? OTHER : '1;
    return (ecause & ~clr) | cause_evt;
  endfunction

  task automatic check(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    #1;
    check(tag, "msg_valid", {{(N-1){1'b0}}, msg_valid}, {{(N-1){1'b0}}, exp_valid()});
    check(tag, "msg_causes", msg_causes, ecause);
    check(tag, "host_rdata", host_rdata, host_sel ? emask : ecause);
    @(posedge clk);
    if (!rst_n) begin
      ecause = '0; emask = '0; ecnt = interval;
    end else begin
      logic f = exp_valid() && msg_ready;
      ecause = exp_next_cause();
      if (host_wr && host_sel) emask = host_wdata;
      if (f) ecnt = interval;
      else if (ecnt != '0) ecnt = ecnt - 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cause_evt = '0; host_wr = 0; host_rd = 0; host_sel = 0; host_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    ecause = 'x; emask = 'x; ecnt = 'x;
    @(negedge clk);
    cause_evt = 8'hFF; host_wr = 1; host_sel = 1; host_wdata = 8'hFF;
    repeat (2) begin @(posedge clk); ecause = '0; emask = '0; ecnt = interval; @(negedge clk); end
    idle();
    step("R1");
    rst_n = 1;
    step("R1");
    cause_evt = 8'h01; step("R2");
    cause_evt = '0;
    repeat (5) step("R2 R3 R4");
    host_sel = 1; host_wr = 1; host_wdata = 8'h0F; step("R10");
    idle(); host_sel = 1; host_rd = 1; step("R10");
    idle(); cause_evt = 8'h30; step("R2");
    idle(); msg_ready = 1; step("R5");
    repeat (3) step("R5 R4");
    host_wr = 1; host_wdata = 8'h10; step("R6");
    idle(); step("R6");
    cause_evt = 8'hFF; step("R2");
    idle(); rd_other_only = 1; host_rd = 1; step("R7");
    idle(); step("R7");
    rd_other_only = 0; host_rd = 1; step("R7");
    idle(); step("R7");
    cause_evt = 8'h81; host_rd = 1; host_wr = 1; host_wdata = 8'hFF; step("R8");
    idle(); step("R8");
    interval = '0;
    repeat (4) step("R9");
    cause_evt = 8'h01; step("R9");
    idle(); repeat (3) step("R9");
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 50 == 0) interval = TW'($urandom % 16);
      cause_evt = ($urandom % 4 == 0) ? N'($urandom & $urandom) : '0;
      msg_ready = ($urandom % 4) != 0;
      host_sel = ($urandom % 5) == 0;
      host_wr = ($urandom % 8) == 0;
      host_rd = ($urandom % 8) == 0;
      host_wdata = N'($urandom);
      rd_other_only = $urandom % 2;
      rst_n = ($urandom % 500) != 0;
      step("R3 R4 R5");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule